// File: doc/BRIEF.md
# ADC Scan Trigger Controller

This block sits in front of an ADC scan engine and decides when a conversion scan begins. Software starts a scan with a start strobe in the control register. When sync triggering is armed, the rising edge of an external sync line can start a scan as well. While a scan runs, the block issues one sample request per slot, follows the slot index as the converter returns done strobes, and closes the scan after the programmed number of slots.

Two scan modes are available. A one-shot scan runs its slots once and then stops. A looping scan restarts at slot 0 after each pass until software asks it to stop. After every completed pass the block sets a sticky end-of-scan flag, which software clears by writing 1 to it. The interrupt line is that flag gated by its enable bit. In one-shot mode, an accepted sync edge disarms sync triggering in hardware, so a second pulse cannot start another scan by accident. Software may re-arm sync triggering whenever it likes, including in the middle of a scan.

Top module: `adc_scan_trig`

## Requirements
- R1: After reset, scan_active, smp_req, slot_idx and eos_irq are 0, and reads of CTRL (address 0) and STAT (address 2) return 0.
- R2: While the sync-enable bit (CTRL bit 2) is 0, rising edges on sync_in never start a scan.
- R3: A CTRL write with bit 0 set starts a scan from idle whether or not sync triggering is enabled. In the cycle after the write, scan_active is 1 and slot_idx is 0.
- R4: With the sync-enable bit set, a rising edge on sync_in starts a scan. scan_active rises at the second clock edge that samples sync_in high.
- R5: In one-shot mode (CTRL bit 3 = 0), a sync edge seen while sync is enabled clears the sync-enable bit, as read back in CTRL bit 2. Later sync edges are then ignored.
- R6: Writing the sync-enable bit to 1 during a scan leaves scan_active and slot_idx undisturbed.
- R7: A start request that arrives while a scan is active is ignored, and slot_idx keeps its value.
- R8: LEN (address 1, bits 2:0) holds the slot count minus 1. Each smp_done advances slot_idx by 1. A one-shot scan ends after LEN+1 done strobes, and slot_idx returns to 0.
- R9: Completing a scan sets the end-of-scan flag (STAT bit 0). eos_irq equals that flag ANDed with the interrupt-enable bit (CTRL bit 4).
- R10: In looping mode (CTRL bit 3 = 1), each completed pass sets the flag, restarts slot_idx at 0 and keeps scan_active high.
- R11: A CTRL write with bit 1 set during a looping scan ends the scan at the end of the current pass, and that final pass still sets the flag.
- R12: Writing 1 to STAT bit 0 clears the flag. Writing 0 leaves it set.
- R13: smp_req pulses for one cycle when a scan starts and after every done strobe that does not end the scan. It is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 LEN, 2 STAT |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sync_in | input | 1 | External sync trigger line |
| smp_done | input | 1 | Converter finished the current slot |
| scan_active | output | 1 | A scan is in progress |
| smp_req | output | 1 | One-cycle request to sample the current slot |
| slot_idx | output | 3 | Index of the current slot |
| eos_irq | output | 1 | End-of-scan interrupt |

## Verification
The hardest case to reach is software re-arming sync triggering in the middle of a one-shot scan that a sync edge started. Reaching it needs a sync-started scan, a check that hardware has cleared the enable bit, and then a CTRL write with the enable set while done strobes are still outstanding. The bench drives that order with a directed sequence. It also sends a software start during the same scan to show that the scan is not restarted. Afterwards it sends one more sync edge once the scan has finished, to show that re-arming took effect.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LEN  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    // CTRL bit positions (write and read)
    localparam int CB_START = 0;  // write: start strobe, read: scan active
    localparam int CB_STOP  = 1;  // write: stop strobe,  read: stop pending
    localparam int CB_SYNC  = 2;
    localparam int CB_LOOP  = 3;
    localparam int CB_IE    = 4;

    typedef struct packed {
        logic eos_ie;
        logic loop_mode;
        logic sync_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.eos_ie    = w[CB_IE];
        c.loop_mode = w[CB_LOOP];
        c.sync_en   = w[CB_SYNC];
        return c;
    endfunction
endpackage

// File: rtl/adc_scan_sync_edge.sv
module adc_scan_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic sync_pulse
);
    logic s_d1, s_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_d1 <= 1'b0;
            s_d2 <= 1'b0;
        end else begin
            s_d1 <= sync_in;
            s_d2 <= s_d1;
        end
    end

    assign sync_pulse = s_d1 & ~s_d2;
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              sync_trig,
    input  logic              scan_active,
    input  logic              stop_pend,
    input  logic              eos_set,
    output ctrl_t             ctrl,
    output logic [SLOT_W-1:0] len,
    output logic              eos_flag,
    output logic              sw_start,
    output logic              stop_wr,
    output logic              eos_irq,
    output logic [DATA_W-1:0] reg_rdata
);
    logic we_ctrl, we_len, we_stat;

    assign we_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
    assign we_len   = reg_we && (reg_addr == ADDR_LEN);
    assign we_stat  = reg_we && (reg_addr == ADDR_STAT);
    assign sw_start = we_ctrl && reg_wdata[CB_START];
    assign stop_wr  = we_ctrl && reg_wdata[CB_STOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            len      <= '0;
            eos_flag <= 1'b0;
        end else begin
            if (we_ctrl)
                ctrl <= ctrl_from_word(reg_wdata);
            else if (sync_trig && !ctrl.loop_mode)
                ctrl.sync_en <= 1'b0;
            if (we_len)
                len <= reg_wdata[SLOT_W-1:0];
            if (eos_set)
                eos_flag <= 1'b1;
            else if (we_stat && reg_wdata[0])
                eos_flag <= 1'b0;
        end
    end

    assign eos_irq = eos_flag & ctrl.eos_ie;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CB_START] = scan_active;
                reg_rdata[CB_STOP]  = stop_pend;
                reg_rdata[CB_SYNC]  = ctrl.sync_en;
                reg_rdata[CB_LOOP]  = ctrl.loop_mode;
                reg_rdata[CB_IE]    = ctrl.eos_ie;
            end
            ADDR_LEN:  reg_rdata[SLOT_W-1:0] = len;
            ADDR_STAT: reg_rdata[0] = eos_flag;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              smp_done,
    input  logic              stop_wr,
    input  logic              loop_mode,
    input  logic [SLOT_W-1:0] len,
    output logic              scan_active,
    output logic              smp_req,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              stop_pend,
    output logic              eos_set
);
    logic at_last, pass_done, end_now, start_ok;

    assign at_last   = (slot_idx == len);
    assign pass_done = scan_active && smp_done && at_last;
    assign end_now   = pass_done && (!loop_mode || stop_pend || stop_wr);
    assign start_ok  = start_req && !scan_active;
    assign eos_set   = pass_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_active <= 1'b0;
            smp_req     <= 1'b0;
            slot_idx    <= '0;
            stop_pend   <= 1'b0;
        end else begin
            smp_req <= 1'b0;
            if (start_ok) begin
                scan_active <= 1'b1;
                slot_idx    <= '0;
                smp_req     <= 1'b1;
                stop_pend   <= 1'b0;
            end else if (scan_active) begin
                if (stop_wr)
                    stop_pend <= 1'b1;
                if (smp_done) begin
                    if (at_last) begin
                        slot_idx <= '0;
                        if (end_now) begin
                            scan_active <= 1'b0;
                            stop_pend   <= 1'b0;
                        end else begin
                            smp_req <= 1'b1;
                        end
                    end else begin
                        slot_idx <= slot_idx + 1'b1;
                        smp_req  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_scan_trig.sv
module adc_scan_trig
    import adc_scan_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sync_in,
    input  logic              smp_done,
    output logic              scan_active,
    output logic              smp_req,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              eos_irq
);
    logic              sync_pulse, sync_trig, start_req;
    logic              sw_start, stop_wr, stop_pend, eos_set, eos_flag;
    ctrl_t             ctrl;
    logic [SLOT_W-1:0] len;

    adc_scan_sync_edge u_sync (
        .clk(clk), .rst(rst), .sync_in(sync_in), .sync_pulse(sync_pulse)
    );

    assign sync_trig = sync_pulse && ctrl.sync_en;
    assign start_req = sw_start || sync_trig;

    adc_scan_regs #(.SLOT_W(SLOT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sync_trig(sync_trig), .scan_active(scan_active),
        .stop_pend(stop_pend), .eos_set(eos_set), .ctrl(ctrl), .len(len),
        .eos_flag(eos_flag), .sw_start(sw_start), .stop_wr(stop_wr),
        .eos_irq(eos_irq), .reg_rdata(reg_rdata)
    );

    adc_scan_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .smp_done(smp_done),
        .stop_wr(stop_wr), .loop_mode(ctrl.loop_mode), .len(len),
        .scan_active(scan_active), .smp_req(smp_req), .slot_idx(slot_idx),
        .stop_pend(stop_pend), .eos_set(eos_set)
    );
endmodule

// File: rtl/adc_scan_trig_chk.sv
module adc_scan_trig_chk #(
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic              sync_pulse,
    input logic              sync_en,
    input logic              loop_mode,
    input logic              stop_pend,
    input logic              smp_done,
    input logic              scan_active,
    input logic              smp_req,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [SLOT_W-1:0] len,
    input logic              eos_flag
);
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        scan_active |-> slot_idx <= len);  // R8
    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !scan_active |-> slot_idx == '0);  // R8
    AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        smp_req |-> scan_active);  // R13
    AST_START_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_active) |-> (slot_idx == '0) && smp_req);  // R3
    AST_SYNC_DISARM: assert property (@(posedge clk) disable iff (rst)
        (sync_pulse && sync_en && !loop_mode && !(reg_we && reg_addr == 2'd0)) |=> !sync_en);  // R5
    AST_FLAG_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        (scan_active && smp_done && slot_idx == len) |=> eos_flag);  // R9
    AST_LOOP_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (scan_active && loop_mode && !stop_pend && !(reg_we && reg_addr == 2'd0)
         && smp_done && slot_idx == len) |=> scan_active && slot_idx == '0);  // R10
endmodule

bind adc_scan_trig adc_scan_trig_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .sync_pulse(sync_pulse), .sync_en(ctrl.sync_en), .loop_mode(ctrl.loop_mode),
    .stop_pend(stop_pend), .smp_done(smp_done), .scan_active(scan_active),
    .smp_req(smp_req), .slot_idx(slot_idx), .len(len), .eos_flag(eos_flag)
);

// File: tb/adc_scan_trig_tb_top.sv
`timescale 1ns/1ps
module adc_scan_trig_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sync_in = 1'b0;
    logic       smp_done = 1'b0;
    logic       scan_active, smp_req, eos_irq;
    logic [2:0] slot_idx;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    adc_scan_trig dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
        .smp_done(smp_done), .scan_active(scan_active), .smp_req(smp_req),
        .slot_idx(slot_idx), .eos_irq(eos_irq)
    );

    // table entry: [2:0] slots-1, [3] irq enable, [4] start by sync, [5] expected irq
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h28, 8'h17, 8'h3B, 8'h01, 8'h2D, 8'h3A};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        smp_done = 1'b1;
        tick();
        smp_done = 1'b0;
    endtask

    task automatic sync_start();
        sync_in = 1'b1;
        tick();
        tick();
        sync_in = 1'b0;
    endtask

    // walk one pass of n slots starting from the cycle with smp_req high
    task automatic run_pass(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            check(req, slot_idx, k);
            check("R13", smp_req, 1);
            tick();
            check("R13", smp_req, 0);
            pulse_done();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1", scan_active, 0);
        check("R1", smp_req, 0);
        check("R1", slot_idx, 0);
        check("R1", eos_irq, 0);
        rd(2'd0, r); check("R1", r, 0);
        rd(2'd2, r); check("R1", r, 0);

        // table-driven one-shot scans
        for (int i = 0; i < NVEC; i++) begin
            int n;
            n = int'(VEC[i][2:0]) + 1;
            wr(2'd1, {5'd0, VEC[i][2:0]});
            wr(2'd0, {3'd0, VEC[i][3], 1'b0, VEC[i][4], 2'b00});
            wr(2'd2, 8'h01);
            if (VEC[i][4]) begin
                sync_start();
                check("R4", scan_active, 1);
                rd(2'd0, r); check("R5", r[2], 0);
            end else begin
                wr(2'd0, {3'd0, VEC[i][3], 4'b0001});
                check("R3", scan_active, 1);
            end
            run_pass(n, "R8");
            check("R8", scan_active, 0);
            check("R8", slot_idx, 0);
            rd(2'd2, r); check("R9", r[0], 1);
            check("R9", eos_irq, int'(VEC[i][5]));
        end

        // R2: sync disabled
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h00);
        sync_start();
        repeat (3) tick();
        check("R2", scan_active, 0);

        // R5/R6/R7: one-shot sync scan, re-arm mid-scan, ignored start
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h04);
        sync_start();
        check("R4", scan_active, 1);
        rd(2'd0, r); check("R5", r[2], 0);
        tick();
        pulse_done();
        check("R8", slot_idx, 1);
        sync_start();  // disarmed: no effect
        check("R5", slot_idx, 1);
        check("R5", scan_active, 1);
        wr(2'd0, 8'h04);  // re-arm during scan
        check("R6", scan_active, 1);
        check("R6", slot_idx, 1);
        rd(2'd0, r); check("R6", r[2], 1);
        wr(2'd0, 8'h05);  // start while active
        check("R7", slot_idx, 1);
        check("R7", smp_req, 0);
        pulse_done(); pulse_done(); pulse_done();
        check("R8", scan_active, 0);
        sync_start();  // re-armed edge starts a new scan
        check("R5", scan_active, 1);
        run_pass(4, "R8");
        check("R8", scan_active, 0);

        // R9 gating of interrupt
        wr(2'd2, 8'h01);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h01);
        run_pass(1, "R8");
        check("R9", eos_irq, 0);
        wr(2'd0, 8'h10);
        check("R9", eos_irq, 1);

        // R10/R11/R12 looping
        wr(2'd2, 8'h01);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'h19);
        run_pass(2, "R10");
        check("R10", scan_active, 1);
        check("R10", slot_idx, 0);
        check("R13", smp_req, 1);
        check("R10", eos_irq, 1);
        wr(2'd2, 8'h00);
        rd(2'd2, r); check("R12", r[0], 1);
        wr(2'd2, 8'h01);
        rd(2'd2, r); check("R12", r[0], 0);
        check("R10", scan_active, 1);
        pulse_done(); pulse_done();
        rd(2'd2, r); check("R10", r[0], 1);
        check("R10", scan_active, 1);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h1A);  // stop, keep loop and irq enable
        rd(2'd0, r); check("R11", r[1], 1);
        check("R11", scan_active, 1);
        pulse_done();
        check("R11", scan_active, 1);
        pulse_done();
        check("R11", scan_active, 0);
        rd(2'd2, r); check("R11", r[0], 1);
        check("R13", smp_req, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule